// File: doc/BRIEF.md
# I2C Burst Receive Controller

This block is the data-phase receiver of an I2C master. Once address and bus-start handling elsewhere have put a slave into read mode, software writes a single control word that holds a byte count and a flag saying whether the final byte should be refused. The controller then clocks the bus by itself for the whole burst. For each byte it shifts in eight bits, most significant first, then answers with ACK or NAK on the ninth clock. It pushes every byte into a 64-entry receive FIFO. When the count runs out it releases the bus and raises a sticky read-complete flag, which can also drive an interrupt.

Long reads are split into several bursts of up to one FIFO depth each. Every burst except the last keeps the NAK flag clear, so the slave keeps sending. Bit timing comes from an external `tick` strobe: each tick moves the SCL waveform by one quarter of a bit. The line drivers are open-drain enables, so `scl_oe`/`sda_oe` high pulls the wire low. If the FIFO fills during a burst, the controller holds SCL low in front of the acknowledge clock until software frees a slot.

Top module: `i2c_rx_burst`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge): `busy`=0, `rd_done`=0, `irq`=0, `scl_oe`=0, `sda_oe`=0, `rx_empty`=1 and `rx_level`=0.
- R2: A `ctl_wr` pulse while idle starts a burst on that edge. `ctl_wdata[6:0]` is the byte count and `ctl_wdata[7]` is the last-byte-NAK flag. A count above 64 is handled as 64. `busy` reads 1 from the next cycle until the burst ends.
- R3: Each bit lasts four `tick` strobes. SCL is driven low (`scl_oe`=1) for the first two and released for the last two. `sda_in` is sampled on the tick that ends the first released quarter, with data bits taken MSB first. An N-byte burst produces 9N+1 SCL low periods and uses 36N+2 ticks when the FIFO never fills.
- R4: On the ninth clock of each byte, `sda_oe` is 1 (ACK). The only exception is the final byte of a burst whose NAK flag is set, where `sda_oe` is 0 (NAK). `sda_oe` changes only while SCL is held low, both before and after the change.
- R5: Each received byte enters the FIFO. `rd_data` shows the oldest stored byte, and a `rd_pop` pulse removes it. A `rd_pop` while the FIFO is empty has no effect.
- R6: After the last acknowledge clock, the controller releases SDA during one more low quarter and then ends the burst. `busy` falls, `rd_done` is set on the same edge, and both line enables read 0.
- R7: A start with count 0 sets `rd_done` on the write edge. It never asserts `busy` and makes no SCL activity.
- R8: A `ctl_wr` while `busy` is 1 is ignored. It changes neither the running count nor the NAK choice.
- R9: `rd_done` stays set until a `done_clr` pulse. `irq` equals `rd_done` AND an enable bit loaded from `ien_wdata` on `ien_wr`.
- R10: When the FIFO holds 64 bytes at the start of an acknowledge clock, the controller keeps SCL low and waits. It resumes only after a pop frees a slot, so no byte is lost or overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe (starts a burst) |
| ctl_wdata | input | 8 | [6:0] byte count, [7] last-byte-NAK |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 1 | Read-complete interrupt enable value |
| done_clr | input | 1 | Clears the read-complete flag |
| rd_pop | input | 1 | Read of the data-out register; pops one byte |
| rd_data | output | 8 | Oldest byte in the receive FIFO |
| rx_level | output | 7 | Number of bytes held in the FIFO |
| rx_empty | output | 1 | FIFO holds no bytes |
| busy | output | 1 | Burst in progress |
| rd_done | output | 1 | Sticky read-complete flag |
| irq | output | 1 | Read-complete interrupt |
| tick | input | 1 | Quarter-bit timing strobe |
| sda_in | input | 1 | Sampled SDA wire level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Most internal faults surface at the pins within one burst. A wrong slot or phase counter changes the number of SCL low periods or the tick total, and both are counted at the end of each burst. A wrong shift order or sample point corrupts the bytes that come out of the FIFO as soon as they are popped. A wrong byte counter moves the NAK onto the wrong ninth clock or ends the burst early. A faulty full-flag path shows as a lost byte or as SCL released while 64 bytes are held. The latter is observed within a few hundred cycles of stalling.

// File: rtl/i2c_rxb_pkg.sv
// Shared constants and types for the I2C burst receiver.
package i2c_rxb_pkg;
    localparam int BYTE_W  = 8;          // bits per bus byte
    localparam int NAK_POS = 7;          // NAK flag position in the control word
    localparam int CTL_W   = 8;          // control word width
    localparam int SLOT_W  = 4;          // width of the bit-slot counter
    localparam logic [SLOT_W-1:0] ACK_SLOT  = 4'd8;  // ninth clock of a byte
    localparam logic [SLOT_W-1:0] TAIL_SLOT = 4'd9;  // release period after last byte

    // Quarter of a bit period; SCL is low in the first two.
    typedef enum logic [1:0] {
        PH_LOW_A  = 2'd0,
        PH_LOW_B  = 2'd1,
        PH_HIGH_A = 2'd2,
        PH_HIGH_B = 2'd3
    } scl_phase_e;
endpackage

// File: rtl/rxb_fifo.sv
// Receive FIFO with first-word fall-through output.
// Assumes: push is ignored when full and pop is ignored when empty;
// the memory array carries no reset, only pointers and level do.
module rxb_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level_q;
    logic          do_push, do_pop;

    // Qualify requests against occupancy.
    always_comb begin
        do_push = push && (level_q != FULL_LVL);
        do_pop  = pop  && (level_q != '0);
    end

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    // Present the head entry and flags.
    always_comb begin
        dout  = mem[rd_ptr];
        empty = (level_q == '0);
        full  = (level_q == FULL_LVL);
        level = level_q;
    end
endmodule

// File: rtl/rxb_engine.sv
// Bit engine: generates SCL quarter phases from tick, samples SDA MSB first,
// answers ACK/NAK on the ninth clock, then releases the bus after the last byte.
// Assumes: start only arrives while idle with a non-zero clamped count;
// a full FIFO stalls the engine at the start of the acknowledge clock.
module rxb_engine #(
    parameter int CNT_W = 7
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic [CNT_W-1:0]                   start_cnt,
    input  logic                               start_nak,
    input  logic                               tick,
    input  logic                               sda_in,
    input  logic                               fifo_full,
    output logic                               push,
    output logic [i2c_rxb_pkg::BYTE_W-1:0]     push_data,
    output logic                               busy,
    output logic                               finish,
    output logic                               scl_oe,
    output logic                               sda_oe
);
    import i2c_rxb_pkg::*;

    scl_phase_e         phase_q;
    logic               busy_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [CNT_W-1:0]   left_q;
    logic               nak_q;
    logic [BYTE_W-1:0]  shreg_q;
    logic               sda_oe_q;
    logic               ack_drive;

    // Drive SDA low unless this is the final byte of a NAK-terminated burst.
    always_comb begin
        ack_drive = !(nak_q && (left_q == CNT_W'(1)));
    end

    // Sequence slots and phases, shift data and hold the ACK/NAK level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            phase_q  <= PH_LOW_A;
            slot_q   <= '0;
            left_q   <= '0;
            nak_q    <= 1'b0;
            shreg_q  <= '0;
            sda_oe_q <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q   <= 1'b1;
                phase_q  <= PH_LOW_A;
                slot_q   <= '0;
                left_q   <= start_cnt;
                nak_q    <= start_nak;
                sda_oe_q <= 1'b0;
            end
        end else if (tick) begin
            unique case (phase_q)
                PH_LOW_A: begin
                    if (slot_q == ACK_SLOT) begin
                        if (!fifo_full) begin
                            sda_oe_q <= ack_drive;
                            phase_q  <= PH_LOW_B;
                        end
                    end else begin
                        sda_oe_q <= 1'b0;
                        phase_q  <= PH_LOW_B;
                    end
                end
                PH_LOW_B: begin
                    if (slot_q == TAIL_SLOT) begin
                        busy_q <= 1'b0;
                    end else begin
                        phase_q <= PH_HIGH_A;
                    end
                end
                PH_HIGH_A: begin
                    if (slot_q < ACK_SLOT) begin
                        shreg_q <= {shreg_q[BYTE_W-2:0], sda_in};
                    end
                    phase_q <= PH_HIGH_B;
                end
                PH_HIGH_B: begin
                    phase_q <= PH_LOW_A;
                    if (slot_q == ACK_SLOT) begin
                        left_q <= left_q - 1'b1;
                        slot_q <= (left_q == CNT_W'(1)) ? TAIL_SLOT : '0;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                default: phase_q <= PH_LOW_A;
            endcase
        end
    end

    // Derive strobes and line enables from the sequencer state.
    always_comb begin
        push      = busy_q && tick && (phase_q == PH_LOW_A) &&
                    (slot_q == ACK_SLOT) && !fifo_full;
        push_data = shreg_q;
        finish    = busy_q && tick && (phase_q == PH_LOW_B) && (slot_q == TAIL_SLOT);
        busy      = busy_q;
        scl_oe    = busy_q && ((phase_q == PH_LOW_A) || (phase_q == PH_LOW_B));
        sda_oe    = sda_oe_q;
    end
endmodule

// File: rtl/rxb_ctl.sv
// Control and status: decodes the control word, clamps the count to the FIFO
// depth, keeps the sticky read-complete flag and the interrupt enable.
// Assumes: writes arriving while the engine is busy are to be dropped.
module rxb_ctl #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ctl_wr,
    input  logic [i2c_rxb_pkg::CTL_W-1:0]     ctl_wdata,
    input  logic                              ien_wr,
    input  logic                              ien_wdata,
    input  logic                              done_clr,
    input  logic                              busy,
    input  logic                              finish,
    output logic                              start,
    output logic [CNT_W-1:0]                  start_cnt,
    output logic                              start_nak,
    output logic                              rd_done,
    output logic                              irq
);
    import i2c_rxb_pkg::*;

    localparam int FIELD_W = NAK_POS;

    logic [FIELD_W-1:0] field;
    logic               accept, zero_req;
    logic               done_q, ien_q;

    // Decode the control word and clamp the count.
    always_comb begin
        field     = ctl_wdata[FIELD_W-1:0];
        accept    = ctl_wr && !busy;
        zero_req  = accept && (field == '0);
        start     = accept && (field != '0);
        start_nak = ctl_wdata[NAK_POS];
        if (int'(field) > DEPTH) begin
            start_cnt = CNT_W'(DEPTH);
        end else begin
            start_cnt = CNT_W'(field);
        end
    end

    // Hold the read-complete flag; a new completion wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (finish || zero_req) begin
            done_q <= 1'b1;
        end else if (done_clr) begin
            done_q <= 1'b0;
        end
    end

    // Hold the interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (ien_wr) begin
            ien_q <= ien_wdata;
        end
    end

    // Present status.
    always_comb begin
        rd_done = done_q;
        irq     = done_q && ien_q;
    end
endmodule

// File: rtl/i2c_rx_burst.sv
// Top of the I2C burst receiver: control decode, bit engine and receive FIFO.
// Assumes: address and START/STOP phases are handled by neighbouring logic and
// tick is a single-cycle quarter-bit strobe from an external divider.
module i2c_rx_burst #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ctl_wr,
    input  logic [7:0]                   ctl_wdata,
    input  logic                         ien_wr,
    input  logic                         ien_wdata,
    input  logic                         done_clr,
    input  logic                         rd_pop,
    output logic [7:0]                   rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   rx_level,
    output logic                         rx_empty,
    output logic                         busy,
    output logic                         rd_done,
    output logic                         irq,
    input  logic                         tick,
    input  logic                         sda_in,
    output logic                         scl_oe,
    output logic                         sda_oe
);
    import i2c_rxb_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic               start, start_nak, finish, push, fifo_full, eng_busy;
    logic [CNT_W-1:0]   start_cnt;
    logic [BYTE_W-1:0]  push_data;

    rxb_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ien_wr    (ien_wr),
        .ien_wdata (ien_wdata),
        .done_clr  (done_clr),
        .busy      (eng_busy),
        .finish    (finish),
        .start     (start),
        .start_cnt (start_cnt),
        .start_nak (start_nak),
        .rd_done   (rd_done),
        .irq       (irq)
    );

    rxb_engine #(.CNT_W(CNT_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_cnt (start_cnt),
        .start_nak (start_nak),
        .tick      (tick),
        .sda_in    (sda_in),
        .fifo_full (fifo_full),
        .push      (push),
        .push_data (push_data),
        .busy      (eng_busy),
        .finish    (finish),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    rxb_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (push_data),
        .pop   (rd_pop),
        .dout  (rd_data),
        .empty (rx_empty),
        .full  (fifo_full),
        .level (rx_level)
    );

    // Expose the engine activity flag.
    always_comb begin
        busy = eng_busy;
    end
endmodule

// File: rtl/i2c_rx_burst_chk.sv
// Protocol checker for the I2C burst receiver, bound to the top module.
module i2c_rx_burst_chk #(
    parameter int DEPTH = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ctl_wr,
    input logic                        tick,
    input logic                        rd_pop,
    input logic                        busy,
    input logic                        rd_done,
    input logic                        irq,
    input logic                        scl_oe,
    input logic                        sda_oe,
    input logic [$clog2(DEPTH+1)-1:0]  rx_level
);
    localparam int LW = $clog2(DEPTH + 1);

    a_r2_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_wr));

    a_r3_scl_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe) |-> ($past(tick) || $past(ctl_wr)));

    a_r4_sda_changes_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (scl_oe && $past(scl_oe)));

    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LW'(DEPTH));

    a_r6_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    a_r6_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rd_done);

    a_r9_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rd_done);

    a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == LW'(DEPTH) && !rd_pop) |=> (rx_level == LW'(DEPTH)));
endmodule

bind i2c_rx_burst i2c_rx_burst_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .tick     (tick),
    .rd_pop   (rd_pop),
    .busy     (busy),
    .rd_done  (rd_done),
    .irq      (irq),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rx_level (rx_level)
);

// File: tb/i2c_rx_burst_test.sv
module i2c_rx_burst_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       ien_wr = 1'b0;
    logic       ien_wdata = 1'b0;
    logic       done_clr = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] rx_level;
    logic       rx_empty, busy, rd_done, irq, scl_oe, sda_oe;
    logic       tick = 1'b0;
    logic       sda_in = 1'b1;

    i2c_rx_burst #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata), .done_clr(done_clr),
        .rd_pop(rd_pop), .rd_data(rd_data), .rx_level(rx_level),
        .rx_empty(rx_empty), .busy(busy), .rd_done(rd_done), .irq(irq),
        .tick(tick), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Slave model and bus monitor state.
    logic [7:0] slave_mem [DEPTH];
    logic       ack_seen [DEPTH];
    int         fall_cnt = 0;
    int         busy_ticks = 0;
    int         sda_viol = 0;
    int         tick_mode = 0;
    logic       prev_scl = 1'b0;
    logic       prev_sda = 1'b0;
    logic [7:0] exp_q [$];

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    function automatic int clamp(input int f);
        return (f > DEPTH) ? DEPTH : f;
    endfunction

    // Monitor SCL/SDA, feed slave data, and generate tick for the next edge.
    always @(negedge clk) begin
        int pos;
        if (rst_n) begin
            if (scl_oe && !prev_scl) fall_cnt++;
            if (!scl_oe && prev_scl) begin
                pos = fall_cnt - 1;
                if (pos >= 0 && pos % 9 == 8 && pos / 9 < DEPTH) ack_seen[pos/9] = sda_oe;
            end
            if ((sda_oe != prev_sda) && !(scl_oe && prev_scl)) sda_viol++;
        end
        prev_scl = scl_oe;
        prev_sda = sda_oe;
        pos = fall_cnt - 1;
        if (pos < 0 || pos % 9 == 8 || pos >= 9 * DEPTH) sda_in = 1'b1;
        else sda_in = slave_mem[pos/9][7 - pos%9];
        case (tick_mode)
            0:       tick = 1'b1;
            1:       tick = ($urandom % 3 == 0);
            default: tick = 1'b0;
        endcase
        if (busy && tick) busy_ticks++;
    end

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            int g = 0;
            logic [7:0] e;
            while (rx_empty && g < 20000) begin cyc(); g++; end
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
            chk("R5", "fifo byte order", rd_data, e);
            rd_pop = 1'b1;
            cyc();
            rd_pop = 1'b0;
        end
    endtask

    task automatic prep_slave(input int n);
        for (int i = 0; i < DEPTH; i++) ack_seen[i] = 1'b0;
        for (int i = 0; i < n; i++) begin
            slave_mem[i] = 8'($urandom);
            exp_q.push_back(slave_mem[i]);
        end
        fall_cnt = 0;
        busy_ticks = 0;
    endtask

    task automatic check_acks(input int n, input bit nak);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (ack_seen[i] != !(nak && i == n - 1)) bad++;
        end
        chk("R4", "ACK/NAK pattern mismatches", bad, 0);
    endtask

    task automatic run_burst(input int field, input bit nak, input bit mid_write, input bit do_drain);
        int n, lvl0, g;
        n = clamp(field);
        lvl0 = int'(rx_level);
        done_clr = 1'b1; cyc(); done_clr = 1'b0;
        chk("R9", "rd_done cleared", rd_done, 0);
        prep_slave(n);
        ctl_wdata = {nak, 7'(field)};
        ctl_wr = 1'b1; cyc(); ctl_wr = 1'b0;
        chk("R2", "busy after start", busy, 1);
        if (mid_write) begin
            repeat (6) cyc();
            ctl_wdata = {1'b1, 7'd5};
            ctl_wr = 1'b1; cyc(); ctl_wr = 1'b0;
            chk("R8", "busy kept after ignored write", busy, 1);
        end
        g = 0;
        while (busy && g < 30000) begin cyc(); g++; end
        chk("R3", "SCL low periods", fall_cnt, 9 * n + 1);
        chk("R3", "ticks per burst", busy_ticks, 36 * n + 2);
        check_acks(n, nak);
        chk("R4", "SDA changed while SCL released", sda_viol, 0);
        chk("R6", "rd_done at end", rd_done, 1);
        chk("R6", "lines released", {scl_oe, sda_oe}, 0);
        chk("R5", "fifo level after burst", rx_level, lvl0 + n);
        if (do_drain) drain(n);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "rd_done", rd_done, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "line enables", {scl_oe, sda_oe}, 0);
        chk("R1", "rx_empty", rx_empty, 1);
        chk("R1", "rx_level", rx_level, 0);

        // R5: pop on empty ignored
        rd_pop = 1'b1; cyc(); rd_pop = 1'b0; cyc();
        chk("R5", "level after empty pop", rx_level, 0);
        chk("R5", "empty after empty pop", rx_empty, 1);

        // R7: zero count
        fall_cnt = 0;
        ctl_wdata = 8'h80; ctl_wr = 1'b1; cyc(); ctl_wr = 1'b0;
        chk("R7", "rd_done after zero count", rd_done, 1);
        chk("R7", "busy after zero count", busy, 0);
        repeat (20) cyc();
        chk("R7", "no SCL activity", fall_cnt, 0);
        chk("R7", "no bytes stored", rx_level, 0);

        // R9: interrupt enable and clear
        ien_wdata = 1'b1; ien_wr = 1'b1; cyc(); ien_wr = 1'b0;
        chk("R9", "irq with enable", irq, 1);
        ien_wdata = 1'b0; ien_wr = 1'b1; cyc(); ien_wr = 1'b0;
        chk("R9", "irq masked", irq, 0);
        chk("R9", "rd_done held while masked", rd_done, 1);
        ien_wdata = 1'b1; ien_wr = 1'b1; cyc(); ien_wr = 1'b0;
        done_clr = 1'b1; cyc(); done_clr = 1'b0;
        chk("R9", "irq after clear", irq, 0);

        // Directed bursts
        tick_mode = 0;
        run_burst(1, 1'b1, 1'b0, 1'b1);
        chk("R9", "irq after burst", irq, 1);
        run_burst(1, 1'b0, 1'b0, 1'b1);
        run_burst(3, 1'b0, 1'b0, 1'b1);
        run_burst(2, 1'b1, 1'b1, 1'b1);   // R8: write while busy ignored

        // R2 clamp then R10 stall on full FIFO
        run_burst(127, 1'b0, 1'b0, 1'b0);
        chk("R10", "fifo full level", rx_level, DEPTH);
        done_clr = 1'b1; cyc(); done_clr = 1'b0;
        prep_slave(2);
        ctl_wdata = {1'b1, 7'd2}; ctl_wr = 1'b1; cyc(); ctl_wr = 1'b0;
        repeat (200) cyc();
        chk("R10", "busy while stalled", busy, 1);
        chk("R10", "SCL held low while stalled", scl_oe, 1);
        chk("R10", "level while stalled", rx_level, DEPTH);
        chk("R10", "stalled at first ack clock", fall_cnt, 9);
        drain(DEPTH + 2);
        begin
            int g = 0;
            while (busy && g < 5000) begin cyc(); g++; end
        end
        chk("R10", "SCL low periods after stall", fall_cnt, 19);
        check_acks(2, 1'b1);
        chk("R6", "rd_done after stalled burst", rd_done, 1);
        chk("R10", "fifo empty after drain", rx_empty, 1);

        // Random bursts with random tick spacing
        for (int k = 0; k < 6; k++) begin
            int f = 1 + int'($urandom % DEPTH);
            tick_mode = (k % 2 == 0) ? 1 : 0;
            run_burst(f, 1'($urandom), 1'b0, 1'b1);
        end
        tick_mode = 0;
        repeat (5) cyc();
        summary();
    end
endmodule